// File: doc/BRIEF.md
# Byte-Splittable General Register File

This block holds the architectural register state of a 16-bit processor core: four data registers, four pointer/index registers, a fetch pointer and four segment registers. Two combinational read ports and one write port serve the datapath. Each port carries a register select and an access size, so that the four data registers also act as eight independent byte registers.

A byte write changes only the addressed half and leaves the other half as it was. The fetch pointer has its own adder, which steps it forward by a supplied amount whenever the fetch stage asks. A word write from the datapath (a jump target) overrides that step. Writes with a select and size that do not fit together are dropped and reported by a one-cycle error strobe.

Top module: `gp_regfile`

## Requirements
- R1: After reset every register reads as zero, the fetch pointer output is zero and the error strobe is low.
- R2: A word write (size code 0) to any register select 0..12 is returned unchanged by a word read of the same select on either read port. Selects are: 0..3 data registers, 4..7 pointer/index registers, 8 fetch pointer, 9..12 segment registers.
- R3: A low-byte write (size code 1) to a data register (select 0..3) replaces bits 7:0 with write data bits 7:0 and keeps bits 15:8. A high-byte write (size code 2) replaces bits 15:8 with write data bits 7:0 and keeps bits 7:0.
- R4: A byte read (size code 1 or 2) of a data register returns the chosen half in bits 7:0, with bits 15:8 zero.
- R5: A write with a select of 13..15, size code 3, or a byte size on a select of 4..12 changes no register. It raises the error strobe during the cycle that follows the write edge, and only then.
- R6: A read with an invalid select and size combination (as defined in R5) returns zero.
- R7: With the increment request high and no word write to select 8, the fetch pointer advances by the step input at each clock edge. With neither present it holds its value.
- R8: A word write to select 8 in the same cycle as an increment request loads the write data and ignores the increment.
- R9: A read in the same cycle as a write to the same register returns the value held before that write's clock edge.
- R10: The fetch pointer increment wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_sel_i | input | 4 | Write register select |
| wr_size_i | input | 2 | Write size: 0 word, 1 low byte, 2 high byte, 3 invalid |
| wr_data_i | input | 16 | Write data; byte writes use bits 7:0 |
| rd_a_sel_i | input | 4 | Read port A register select |
| rd_a_size_i | input | 2 | Read port A size |
| rd_a_data_o | output | 16 | Read port A data |
| rd_b_sel_i | input | 4 | Read port B register select |
| rd_b_size_i | input | 2 | Read port B size |
| rd_b_data_o | output | 16 | Read port B data |
| fp_inc_i | input | 1 | Fetch pointer increment request |
| fp_step_i | input | 3 | Fetch pointer increment amount |
| fp_o | output | 16 | Current fetch pointer |
| wr_err_o | output | 1 | One-cycle strobe for a dropped write |

## Verification
The checker assumes that write and increment inputs are held stable across each clock edge and are low while reset is asserted. This is because its one-cycle-back comparisons of the fetch pointer and the error strobe start at the first edge after reset is released. The bench changes every input at the falling edge and keeps the write and increment requests low until reset has been released. No checker property bounds the step width, so any step value is legal. Unused select codes 13..15 and size code 3 are driven deliberately, so the checker sees dropped writes as well as legal ones.

// File: rtl/gp_regfile_pkg.sv
package gp_regfile_pkg;
  localparam int SEL_W  = 4;
  localparam int SIZE_W = 2;
  localparam int N_DATA = 4;   // byte-splittable registers at selects 0..N_DATA-1
  localparam int N_REG  = 13;
  localparam int FP_IDX = 8;

  typedef enum logic [SIZE_W-1:0] {
    SZ_WORD = 2'd0,
    SZ_LO   = 2'd1,
    SZ_HI   = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  function automatic logic access_ok(input logic [SEL_W-1:0] sel,
                                     input logic [SIZE_W-1:0] size);
    if (int'(sel) >= N_REG) return 1'b0;
    case (size)
      SZ_WORD:      return 1'b1;
      SZ_LO, SZ_HI: return int'(sel) < N_DATA;
      default:      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rf_lane_dec.sv
module rf_lane_dec
  import gp_regfile_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  output logic [N_REG-1:0]  we_lo_o,
  output logic [N_REG-1:0]  we_hi_o,
  output logic              bad_o
);
  logic ok;

  always_comb begin
    ok    = access_ok(wr_sel_i, wr_size_i);
    bad_o = wr_en_i && !ok;
    for (int i = 0; i < N_REG; i++) begin
      we_lo_o[i] = wr_en_i && ok && (wr_sel_i == SEL_W'(i)) && (wr_size_i != SZ_HI);
      we_hi_o[i] = wr_en_i && ok && (wr_sel_i == SEL_W'(i)) && (wr_size_i != SZ_LO);
    end
  end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
  import gp_regfile_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [N_REG-1:0][DW-1:0] regs_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [SIZE_W-1:0]        size_i,
  output logic [DW-1:0]            data_o
);
  localparam int BW = DW / 2;

  logic [DW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < N_REG; i++)
      if (sel_i == SEL_W'(i)) pick = regs_i[i];
    data_o = '0;
    if (access_ok(sel_i, size_i)) begin
      case (size_i)
        SZ_LO:   data_o[BW-1:0] = pick[BW-1:0];
        SZ_HI:   data_o[BW-1:0] = pick[DW-1:BW];
        default: data_o = pick;
      endcase
    end
  end
endmodule

// File: rtl/rf_fetch_ptr.sv
module rf_fetch_ptr #(
  parameter int DW     = 16,
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DW-1:0]     load_data_i,
  input  logic              inc_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [DW-1:0]     ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_data_i;   // jump target wins
    else if (inc_i)  ptr_o <= ptr_o + DW'(step_i);
  end
endmodule

// File: rtl/gp_regfile.sv
module gp_regfile
  import gp_regfile_pkg::*;
#(
  parameter int DW     = 16,
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_sel_i,
  input  logic [1:0]        wr_size_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [3:0]        rd_a_sel_i,
  input  logic [1:0]        rd_a_size_i,
  output logic [DW-1:0]     rd_a_data_o,
  input  logic [3:0]        rd_b_sel_i,
  input  logic [1:0]        rd_b_size_i,
  output logic [DW-1:0]     rd_b_data_o,
  input  logic              fp_inc_i,
  input  logic [STEP_W-1:0] fp_step_i,
  output logic [DW-1:0]     fp_o,
  output logic              wr_err_o
);
  localparam int BW = DW / 2;

  logic [N_REG-1:0]          we_lo, we_hi;
  logic                      bad_wr;
  logic [BW-1:0]             lo_wdata, hi_wdata;
  logic [N_REG-1:0][DW-1:0]  regs;

  rf_lane_dec u_dec (
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_size_i(wr_size_i),
    .we_lo_o  (we_lo),
    .we_hi_o  (we_hi),
    .bad_o    (bad_wr)
  );

  // byte writes carry their data in the low lane whichever half they target
  assign lo_wdata = wr_data_i[BW-1:0];
  assign hi_wdata = (wr_size_i == SZ_WORD) ? wr_data_i[DW-1:BW] : wr_data_i[BW-1:0];

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    if (i == FP_IDX) begin : g_fp
      rf_fetch_ptr #(.DW(DW), .STEP_W(STEP_W)) u_fp (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (we_lo[i] & we_hi[i]),
        .load_data_i(wr_data_i),
        .inc_i      (fp_inc_i),
        .step_i     (fp_step_i),
        .ptr_o      (regs[i])
      );
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          regs[i] <= '0;
        end else begin
          if (we_lo[i]) regs[i][BW-1:0]  <= lo_wdata;
          if (we_hi[i]) regs[i][DW-1:BW] <= hi_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_err_o <= 1'b0;
    else         wr_err_o <= bad_wr;
  end

  rf_read_mux #(.DW(DW)) u_rd_a (
    .regs_i(regs),
    .sel_i (rd_a_sel_i),
    .size_i(rd_a_size_i),
    .data_o(rd_a_data_o)
  );

  rf_read_mux #(.DW(DW)) u_rd_b (
    .regs_i(regs),
    .sel_i (rd_b_sel_i),
    .size_i(rd_b_size_i),
    .data_o(rd_b_data_o)
  );

  assign fp_o = regs[FP_IDX];
endmodule

// File: rtl/gp_regfile_chk.sv
module gp_regfile_chk #(
  parameter int DW     = 16,
  parameter int STEP_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [3:0]        wr_sel_i,
  input logic [1:0]        wr_size_i,
  input logic [DW-1:0]     wr_data_i,
  input logic [3:0]        rd_a_sel_i,
  input logic [1:0]        rd_a_size_i,
  input logic [DW-1:0]     rd_a_data_o,
  input logic              fp_inc_i,
  input logic [STEP_W-1:0] fp_step_i,
  input logic [DW-1:0]     fp_o,
  input logic              wr_err_o
);
  localparam int BW = DW / 2;

  logic fp_wr, wr_ok, wr_bad, rd_a_ok;

  always_comb begin
    fp_wr   = wr_en_i && (wr_sel_i == 4'd8) && (wr_size_i == 2'd0);
    wr_ok   = (wr_size_i == 2'd0 && wr_sel_i <= 4'd12) ||
              ((wr_size_i == 2'd1 || wr_size_i == 2'd2) && wr_sel_i <= 4'd3);
    wr_bad  = wr_en_i && !wr_ok;
    rd_a_ok = (rd_a_size_i == 2'd0 && rd_a_sel_i <= 4'd12) ||
              ((rd_a_size_i == 2'd1 || rd_a_size_i == 2'd2) && rd_a_sel_i <= 4'd3);
  end

  p_err_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad |=> wr_err_o);
  p_err_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_bad |=> !wr_err_o);
  p_fp_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_inc_i && !fp_wr) |=> fp_o == $past(fp_o) + DW'($past(fp_step_i)));
  p_fp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fp_inc_i && !fp_wr) |=> $stable(fp_o));
  p_fp_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_wr |=> fp_o == $past(wr_data_i));
  p_byte_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_size_i != 2'd0) |-> rd_a_data_o[DW-1:BW] == '0);
  p_bad_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_a_ok |-> rd_a_data_o == '0);
endmodule

bind gp_regfile gp_regfile_chk #(.DW(DW), .STEP_W(STEP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_size_i  (wr_size_i),
  .wr_data_i  (wr_data_i),
  .rd_a_sel_i (rd_a_sel_i),
  .rd_a_size_i(rd_a_size_i),
  .rd_a_data_o(rd_a_data_o),
  .fp_inc_i   (fp_inc_i),
  .fp_step_i  (fp_step_i),
  .fp_o       (fp_o),
  .wr_err_o   (wr_err_o)
);

// File: tb/gp_regfile_bench.sv
module gp_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [3:0]  wsel;
    logic [1:0]  wsize;
    logic [15:0] wdata;
    logic [3:0]  rsel;
    logic [1:0]  rsize;
    logic [15:0] exp;
    logic        err;
  } vec_t;

  // write, then read port A; sizes 0 word, 1 low, 2 high, 3 invalid
  localparam vec_t VECS [NV] = '{
    '{4'd0,  2'd0, 16'h1234, 4'd0,  2'd0, 16'h1234, 1'b0}, // R2
    '{4'd0,  2'd1, 16'h00AB, 4'd0,  2'd0, 16'h12AB, 1'b0}, // R3 low
    '{4'd0,  2'd2, 16'h00CD, 4'd0,  2'd0, 16'hCDAB, 1'b0}, // R3 high
    '{4'd1,  2'd0, 16'h5A5A, 4'd0,  2'd2, 16'h00CD, 1'b0}, // R4 high read
    '{4'd1,  2'd1, 16'h0011, 4'd1,  2'd1, 16'h0011, 1'b0}, // R4 low read
    '{4'd1,  2'd2, 16'h0022, 4'd1,  2'd0, 16'h2211, 1'b0}, // R3
    '{4'd11, 2'd0, 16'hBEEF, 4'd11, 2'd0, 16'hBEEF, 1'b0}, // R2 segment
    '{4'd7,  2'd0, 16'h0F0F, 4'd7,  2'd0, 16'h0F0F, 1'b0}, // R2 index
    '{4'd11, 2'd1, 16'h0000, 4'd11, 2'd0, 16'hBEEF, 1'b1}, // R5 byte to segment
    '{4'd4,  2'd2, 16'h0099, 4'd4,  2'd0, 16'h0000, 1'b1}, // R5 byte to pointer
    '{4'd14, 2'd0, 16'hFFFF, 4'd14, 2'd0, 16'h0000, 1'b1}, // R5/R6 bad select
    '{4'd3,  2'd3, 16'h7777, 4'd3,  2'd0, 16'h0000, 1'b1}, // R5 bad size
    '{4'd2,  2'd0, 16'h8001, 4'd2,  2'd1, 16'h0001, 1'b0}, // R2/R4
    '{4'd2,  2'd2, 16'h00FE, 4'd2,  2'd2, 16'h00FE, 1'b0}  // R3/R4
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [1:0]  wr_size = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_a_sel = '0, rd_b_sel = '0;
  logic [1:0]  rd_a_size = '0, rd_b_size = '0;
  logic [15:0] rd_a_data, rd_b_data, fp;
  logic        fp_inc = 1'b0;
  logic [2:0]  fp_step = '0;
  logic        wr_err;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_regfile u_gp_regfile (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_size_i(wr_size), .wr_data_i(wr_data),
    .rd_a_sel_i(rd_a_sel), .rd_a_size_i(rd_a_size), .rd_a_data_o(rd_a_data),
    .rd_b_sel_i(rd_b_sel), .rd_b_size_i(rd_b_size), .rd_b_data_o(rd_b_data),
    .fp_inc_i(fp_inc), .fp_step_i(fp_step), .fp_o(fp), .wr_err_o(wr_err)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 13; i++) begin
      rd_a_sel = 4'(i); rd_a_size = 2'd0;
      #1 check("R1 reg", rd_a_data, 16'h0000);
    end
    check("R1 fp", fp, 16'h0000);
    check("R1 err", {15'b0, wr_err}, 16'h0000);

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sel = VECS[v].wsel; wr_size = VECS[v].wsize; wr_data = VECS[v].wdata;
      rd_a_sel = VECS[v].rsel; rd_a_size = VECS[v].rsize;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check($sformatf("R2/R3/R4/R6 vec %0d data", v), rd_a_data, VECS[v].exp);
      check($sformatf("R5 vec %0d err", v), {15'b0, wr_err}, {15'b0, VECS[v].err});
    end
    @(negedge clk);
    check("R5 err drops", {15'b0, wr_err}, 16'h0000);

    // R9 read during write returns old value
    wr_en = 1'b1; wr_sel = 4'd0; wr_size = 2'd0; wr_data = 16'h5555;
    rd_b_sel = 4'd0; rd_b_size = 2'd0;
    #1 check("R9 old value", rd_b_data, 16'hCDAB);
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R9 new value", rd_b_data, 16'h5555);

    // R7 increment
    fp_inc = 1'b1; fp_step = 3'd2;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check("R7 step", fp, 16'(2 * k));
    end
    fp_inc = 1'b0;
    @(negedge clk);
    check("R7 hold", fp, 16'h0006);

    // R8 write beats increment
    wr_en = 1'b1; wr_sel = 4'd8; wr_size = 2'd0; wr_data = 16'h1000;
    fp_inc = 1'b1; fp_step = 3'd4;
    @(negedge clk);
    wr_en = 1'b0; fp_inc = 1'b0;
    check("R8 load wins", fp, 16'h1000);

    // R5 byte write to fetch pointer with increment: write dropped, step taken
    wr_en = 1'b1; wr_sel = 4'd8; wr_size = 2'd1; wr_data = 16'h00FF;
    fp_inc = 1'b1; fp_step = 3'd1;
    @(negedge clk);
    wr_en = 1'b0; fp_inc = 1'b0;
    check("R5 fp byte dropped", fp, 16'h1001);
    check("R5 fp byte err", {15'b0, wr_err}, 16'h0001);

    // R10 wrap
    wr_en = 1'b1; wr_sel = 4'd8; wr_size = 2'd0; wr_data = 16'hFFFE;
    @(negedge clk);
    wr_en = 1'b0; fp_inc = 1'b1; fp_step = 3'd3;
    @(negedge clk);
    fp_inc = 1'b0;
    rd_a_sel = 4'd8; rd_a_size = 2'd0;
    #1;
    check("R10 wrap", fp, 16'h0001);
    check("R2 fp via port", rd_a_data, 16'h0001);

    summary();
  end
endmodule